// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Latched Update

The block produces six independent pulse-width modulated outputs, all timed in cycles of its input clock. Each channel is programmed through a small register file that is reached over a plain write/read port. Software writes the wanted cycle length and active-phase length into shadow registers. These values do nothing until software produces a rising edge on the channel's update bit. The new values then move into the active registers that drive the counter.

A self-clearing start bit sets a channel running. A continuous-mode bit must be held set for generation to go on. A polarity bit chooses whether the active phase is driven high or low. The polarity is latched together with the cycle and active lengths. To stop a channel cleanly, software latches an active length of zero, which gives a steady inactive level. Latched values never cut a running cycle short: they take effect at the next cycle boundary, or at once when the channel is not generating.

Top module: `pwm_bank`

## Requirements
- R1: Channel n (0 to 5) owns the address window n*0x20. Inside a window the control register is at offset 0x00, the cycle-length register at 0x08 and the active-length register at 0x0C. Writes to any other offset, or to windows 6 and 7, change nothing, and reads there return 0.
- R2: A control read returns the stored bits 2 (update), 5 (continuous), 8 (polarity) and 9 (auxiliary mode), with all other bits 0, so the start bit (bit 0) always reads 0. A read of offset 0x08 or 0x0C returns the last value written there.
- R3: Writing the cycle-length or active-length register does not change the output until the update bit rises. The update bit rises when a control write has bit 2 = 1 while the stored bit 2 is 0.
- R4: After a control write with bit 0 = 1 and bit 5 = 1, the output in the k-th cycle after that write edge (k = 0, 1, ...) is in its active phase when (k mod P) < D, where P and D are the latched lengths. Latched polarity 1 drives the active phase high. Latched polarity 0 drives it low, with the inactive level high.
- R5: A rising update latches the shadow lengths, together with the polarity in force at that moment, into the active registers. If the channel is generating, the latch happens at the end of the cycle with count P-1, and the new cycle then starts at count 0. If the channel is not generating, the latch happens at the edge of the update write itself.
- R6: A control write with bit 5 = 0 stops the channel and drives the inactive level. A start with bit 5 = 1 restarts the count at 0, including when the channel is already running.
- R7: A latched cycle length of 0 is invalid. The output then holds the inactive level.
- R8: A latched active length equal to or greater than the cycle length gives a constant active level.
- R9: Latching an active length of 0 gives a steady inactive output from the next boundary on.
- R10: After reset, all registers read 0, the latched polarity is normal (1) and every output is 0.
- R11: Each channel's state and output depend only on accesses to that channel's own window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte address: channel in bits 7:5, offset in bits 4:0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address on addr (combinational) |
| pwm_out | output | 6 | One modulated output per channel, bit n for channel n |

## Verification
Directed sequences cover several cases: a plain start, in both polarities; shadow writes left unlatched; an update raised in the middle of a running cycle; active lengths of zero and above the cycle length; a cycle length of zero; a stop and restart; and accesses to unmapped offsets and windows. Each case isolates one rule, such as the boundary latch versus an immediate latch. Constrained random traffic then mixes short cycle lengths, active lengths on both sides of the cycle length and random control bits across all windows. It is compared every cycle against a bench model of the requirements, and so catches cross-channel leakage and wrong timing of latch, restart and stop. Register reads are checked on every cycle against the shadow state that the model predicts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_PER  = 5'h08;
  localparam logic [4:0] OFF_DUTY = 5'h0C;

  localparam int B_START = 0;
  localparam int B_UPD   = 2;
  localparam int B_CONT  = 5;
  localparam int B_POL   = 8;
  localparam int B_AUX   = 9;

  typedef struct packed {
    logic aux;
    logic pol;
    logic cont;
    logic upd;
  } ctrl_t;

  // level on the pin for a given phase and polarity
  function automatic logic drive_level(input logic phase_on, input logic pol);
    return pol ? phase_on : !phase_on;
  endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] shd_per,
  output logic [DATA_W-1:0] shd_duty,
  output logic              ctrl_wr,
  output logic              start_pulse,
  output logic              cont_next,
  output logic              upd_rise,
  output logic              pol_eff
);

  ctrl_t ctrl_q;

  // named events for the core and the assertions
  assign ctrl_wr     = wr_en && (off == OFF_CTRL);
  assign start_pulse = ctrl_wr && wdata[B_START];
  assign cont_next   = wdata[B_CONT];
  assign upd_rise    = ctrl_wr && wdata[B_UPD] && !ctrl_q.upd;
  assign pol_eff     = ctrl_wr ? wdata[B_POL] : ctrl_q.pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      shd_per  <= '0;
      shd_duty <= '0;
    end else if (wr_en) begin
      if (off == OFF_CTRL) begin
        ctrl_q.upd  <= wdata[B_UPD];
        ctrl_q.cont <= wdata[B_CONT];
        ctrl_q.pol  <= wdata[B_POL];
        ctrl_q.aux  <= wdata[B_AUX];
      end
      if (off == OFF_PER)  shd_per  <= wdata;
      if (off == OFF_DUTY) shd_duty <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    case (off)
      OFF_CTRL: begin
        rd_data[B_UPD]  = ctrl_q.upd;
        rd_data[B_CONT] = ctrl_q.cont;
        rd_data[B_POL]  = ctrl_q.pol;
        rd_data[B_AUX]  = ctrl_q.aux;
      end
      OFF_PER:  rd_data = shd_per;
      OFF_DUTY: rd_data = shd_duty;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              start_pulse,
  input  logic              cont_next,
  input  logic              upd_rise,
  input  logic              pol_eff,
  input  logic [DATA_W-1:0] shd_per,
  input  logic [DATA_W-1:0] shd_duty,
  output logic              pwm_o
);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] act_per;
  logic [DATA_W-1:0] act_duty;
  logic              act_pol;
  logic              run_q;
  logic              pend_q;

  logic gen;
  logic wrap;
  logic req;
  logic latch_fire;
  logic phase_on;

  assign gen        = run_q && (act_per != '0);
  assign wrap       = gen && (cnt_q == act_per - 1'b1);
  assign req        = pend_q || upd_rise;
  assign latch_fire = req && (!gen || wrap);
  assign phase_on   = gen && (cnt_q < act_duty);
  assign pwm_o      = drive_level(phase_on, act_pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      act_per  <= '0;
      act_duty <= '0;
      act_pol  <= 1'b1;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (latch_fire) begin
        act_per  <= shd_per;
        act_duty <= shd_duty;
        act_pol  <= pol_eff;
      end
      pend_q <= req && !latch_fire;
      if (ctrl_wr) run_q <= cont_next ? (run_q | start_pulse) : 1'b0;
      if (start_pulse && cont_next)  cnt_q <= '0;
      else if (latch_fire || wrap)   cnt_q <= '0;
      else if (gen)                  cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gen |-> (cnt_q < act_per));

  p_latch_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> (cnt_q == '0));

  p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fire |=> ($stable(act_per) && $stable(act_duty) && $stable(act_pol)));

  p_start_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && cont_next) |=> (run_q && cnt_q == '0));

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !cont_next) |=> (pwm_o == !act_pol));

  p_zero_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per == '0) |-> (pwm_o == !act_pol));

  p_full_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && act_duty >= act_per) |-> (pwm_o == act_pol));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int CH_W = ADDR_W - 5;

  logic [CH_W-1:0]   ch_sel;
  logic [4:0]        off;
  logic [DATA_W-1:0] rd_bus [NUM_CH];

  assign ch_sel = addr[ADDR_W-1:5];
  assign off    = addr[4:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              ch_wr;
    logic [DATA_W-1:0] shd_per;
    logic [DATA_W-1:0] shd_duty;
    logic              ctrl_wr;
    logic              start_pulse;
    logic              cont_next;
    logic              upd_rise;
    logic              pol_eff;

    assign ch_wr = wr_en && (ch_sel == CH_W'(i));

    pwm_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ch_wr),
      .off         (off),
      .wdata       (wdata),
      .rd_data     (rd_bus[i]),
      .shd_per     (shd_per),
      .shd_duty    (shd_duty),
      .ctrl_wr     (ctrl_wr),
      .start_pulse (start_pulse),
      .cont_next   (cont_next),
      .upd_rise    (upd_rise),
      .pol_eff     (pol_eff)
    );

    pwm_chan_core #(.DATA_W(DATA_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_wr     (ctrl_wr),
      .start_pulse (start_pulse),
      .cont_next   (cont_next),
      .upd_rise    (upd_rise),
      .pol_eff     (pol_eff),
      .shd_per     (shd_per),
      .shd_duty    (shd_duty),
      .pwm_o       (pwm_out[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_W'(i)) rdata = rd_bus[i];
    end
  end

  p_unmapped_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_sel >= CH_W'(NUM_CH)) |-> (rdata == '0));

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R10";

  always #5 clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // bench model of the requirements
  logic [31:0] m_sper [NCH], m_sduty [NCH], m_aper [NCH], m_aduty [NCH], m_cnt [NCH];
  bit m_upd [NCH], m_cont [NCH], m_pol [NCH], m_aux [NCH];
  bit m_run [NCH], m_pend [NCH], m_apol [NCH];

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_sper[c] = 0; m_sduty[c] = 0; m_aper[c] = 0; m_aduty[c] = 0; m_cnt[c] = 0;
      m_upd[c] = 0; m_cont[c] = 0; m_pol[c] = 0; m_aux[c] = 0;
      m_run[c] = 0; m_pend[c] = 0; m_apol[c] = 1;
    end
  endtask

  function automatic bit exp_out(int c);
    bit g = m_run[c] && (m_aper[c] != 0);
    bit on = g && ((m_cnt[c] % m_aper[c]) < m_aduty[c]);
    return m_apol[c] ? on : !on;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int c = int'(a[7:5]);
    logic [31:0] v = 0;
    if (c >= NCH) return 0;
    case (a[4:0])
      5'h00: begin v[2] = m_upd[c]; v[5] = m_cont[c]; v[8] = m_pol[c]; v[9] = m_aux[c]; end
      5'h08: v = m_sper[c];
      5'h0C: v = m_sduty[c];
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_step(bit w, logic [7:0] a, logic [31:0] d);
    for (int c = 0; c < NCH; c++) begin
      bit wc = w && (int'(a[7:5]) == c);
      bit g = m_run[c] && (m_aper[c] != 0);
      bit wr_ = g && (m_cnt[c] == m_aper[c] - 1);
      bit cw = wc && (a[4:0] == 5'h00);
      bit ur = cw && d[2] && !m_upd[c];
      bit rq = m_pend[c] || ur;
      bit lt = rq && (!g || wr_);
      bit pe = cw ? d[8] : m_pol[c];
      if (cw && d[0] && d[5]) m_cnt[c] = 0;
      else if (lt || wr_)     m_cnt[c] = 0;
      else if (g)             m_cnt[c] = m_cnt[c] + 1;
      if (lt) begin m_aper[c] = m_sper[c]; m_aduty[c] = m_sduty[c]; m_apol[c] = pe; end
      m_pend[c] = rq && !lt;
      if (cw) begin
        m_run[c] = d[5] ? (m_run[c] | d[0]) : 1'b0;
        m_upd[c] = d[2]; m_cont[c] = d[5]; m_pol[c] = d[8]; m_aux[c] = d[9];
      end
      if (wc && a[4:0] == 5'h08) m_sper[c] = d;
      if (wc && a[4:0] == 5'h0C) m_sduty[c] = d;
    end
  endtask

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) check(tag, 32'(pwm_out[c]), 32'(exp_out(c)));
    check({tag, " read"}, rdata, exp_rd(addr));
  endtask

  task automatic step(bit w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    compare_all();
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    if (rst_n) model_step(w, a, d); else model_reset();
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); step(1, a, d); endtask
  task automatic idle(int n, logic [7:0] a);
    for (int i = 0; i < n; i++) step(0, a, 0);
  endtask

  initial begin
    int unsigned seed = $urandom(32'h5EED);
    model_reset();
    // R10: reset state
    tag = "R10";
    for (int i = 0; i < 4; i++) step(0, 8'(i * 32), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2, 8'h08);
    check("R10 outputs after reset", 32'(pwm_out), 32'h0);
    check("R10 period reads 0", rdata, 32'h0);

    // R4: basic waveform, channel 0, P=5 D=2
    tag = "R4";
    wr(8'h08, 5); wr(8'h0C, 2); wr(8'h00, 32'h320); wr(8'h00, 32'h325);
    idle(12, 8'h00);
    // R2: start bit reads back 0
    check("R2 ctrl readback", rdata, 32'h324);

    // R3: shadow writes without an update
    tag = "R3";
    wr(8'h08, 8); wr(8'h0C, 6);
    idle(11, 8'h08);
    check("R2 period shadow readback", rdata, 32'd8);

    // R5: update raised mid-cycle, latched at boundary
    tag = "R5";
    wr(8'h00, 32'h320); idle(1, 8'h00); wr(8'h00, 32'h324);
    idle(20, 8'h0C);

    // R9: zero active length as disable
    tag = "R9";
    wr(8'h0C, 0); wr(8'h00, 32'h320); wr(8'h00, 32'h324);
    idle(20, 8'h00);
    check("R9 steady inactive", 32'(pwm_out[0]), 32'h0);

    // R8: active length above cycle length, channel 1
    tag = "R8";
    wr(8'h28, 4); wr(8'h2C, 9); wr(8'h20, 32'h325);
    idle(10, 8'h28);
    check("R8 constant active", 32'(pwm_out[1]), 32'h1);

    // R6: stop and restart channel 1
    tag = "R6";
    wr(8'h20, 32'h300);
    idle(3, 8'h20);
    check("R6 stopped inactive", 32'(pwm_out[1]), 32'h0);
    wr(8'h2C, 1); wr(8'h20, 32'h325); idle(9, 8'h20);

    // R7: zero cycle length, channel 2
    tag = "R7";
    wr(8'h4C, 3); wr(8'h40, 32'h325);
    idle(6, 8'h40);
    check("R7 zero period inactive", 32'(pwm_out[2]), 32'h0);

    // R4: inverted polarity, channel 3
    tag = "R4";
    wr(8'h68, 6); wr(8'h6C, 2); wr(8'h60, 32'h225);
    idle(14, 8'h68);

    // R1: unmapped offsets and windows
    tag = "R1";
    wr(8'h84, 32'hABCD); wr(8'hC8, 32'h1234); wr(8'hEC, 32'h55);
    step(0, 8'h84, 0); check("R1 unmapped offset", rdata, 32'h0);
    step(0, 8'hC8, 0); check("R1 unmapped window", rdata, 32'h0);
    // R2: ctrl with start reads without start
    wr(8'h80, 32'h327); step(0, 8'h80, 0);
    check("R2 ctrl mask", rdata, 32'h324);

    // R11: constrained random across all windows
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int unsigned pick = $urandom_range(0, 4);
      a[7:5] = 3'($urandom_range(0, 7));
      case (pick)
        0, 1: a[4:0] = 5'h00;
        2: a[4:0] = 5'h08;
        3: a[4:0] = 5'h0C;
        default: a[4:0] = 5'h10;
      endcase
      case (a[4:0])
        5'h08: d = $urandom_range(0, 9);
        5'h0C: d = $urandom_range(0, 11);
        default: begin
          d = $urandom & 32'h325;
          if ($urandom_range(0, 3) != 0) d[5] = 1'b1;
        end
      endcase
      if ($urandom_range(0, 3) == 0) step(1, a, d);
      else step(0, a, 0);
    end
    idle(2, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule